// File: doc/BRIEF.md
# Timer clock source selector

This block turns a 3-bit clock-select code into a single-cycle count-enable strobe for a timer/counter. The strobe can be held off (timer stopped) or raised on every system clock cycle. It can also come from one of four taps of a shared free-running prescaler, which divide the system clock by 8, 64, 256 or 1024. The last two codes take it from falling or rising edges on an external clock pin. Every strobe is synchronous to the system clock. The external pin passes through a two-flop synchronizer before its edges are detected.

The select code is registered inside the block. After reset it reads as the stop code, whatever the input carries. The prescaler is a 10-bit counter that starts from zero when reset is released and runs without a break. Changing the select code never restarts it, so every divided tap keeps a fixed phase against reset release. The counter, the compare logic and the register interface that drives the select code all sit outside this block.

Top module: `tcs_clock_select`

## Requirements
- R1: While reset is asserted, and on the first rising edge after its release, count_en is 0 and the stored select code is 000, whatever value clk_sel carries.
- R2: With code 000 (stop), count_en stays 0.
- R3: With code 001 (direct), count_en is 1 on every cycle.
- R4: Codes 010, 011, 100 and 101 give one-cycle count_en pulses spaced exactly 8, 64, 256 and 1024 cycles apart.
- R5: The prescaler counts rising edges from reset release and never restarts. With a divide-by-N code, count_en is 1 just after the k-th rising edge since reset release (counting from 1) exactly when k is a multiple of N. This phase holds across changes of select code.
- R6: With code 110, each falling edge of ext_clk_pin gives exactly one count_en pulse. The pulse is visible after the third rising edge of clk following the pin change.
- R7: With code 111, each rising edge of ext_clk_pin gives exactly one count_en pulse, with the same three-edge delay.
- R8: In either external mode, a pin edge of the opposite polarity gives no pulse.
- R9: A new clk_sel value changes count_en on the second rising edge of clk after it is presented: one edge loads the stored code, and the next edge updates the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| clk_sel | input | 3 | Clock-select code |
| ext_clk_pin | input | 1 | External clock pin, asynchronous to clk |
| count_en | output | 1 | One-cycle count-enable strobe for the timer |

## Verification
Each path to count_en has a fixed latency. A select change shows two rising edges after it is presented. A prescaler tap decided at edge k shows just after edge k. An external pin change shows after the third rising edge: two synchronizer flops, then the output register. The bench drives every input at a falling edge and samples count_en at later falling edges. It keeps its own count of rising edges since reset release, and from that count it predicts the exact cycle of each divided pulse. For external edges it checks the six cycles after each pin change, so it rejects both a missing pulse and a late pulse.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int unsigned PRESC_W  = 10;
  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    CS_STOP     = 3'd0,
    CS_DIRECT   = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } cs_code_e;

  // log2 of the divide ratio for each prescaler tap
  function automatic int unsigned tap_log2(input int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int unsigned CNT_W = tcs_pkg::PRESC_W,
  parameter int unsigned NTAP  = tcs_pkg::NUM_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] tap_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // a tap fires when all of its low-order bits are about to roll over
  for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
    localparam int unsigned LB = tcs_pkg::tap_log2(gi);
    assign tap_o[gi] = &cnt_q[LB-1:0];
    if (gi > 0) begin : g_nest
      AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o[gi] |-> tap_o[gi-1]); // R4
    end
  end

  AST_TAP8_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o[0] |=> !tap_o[0]); // R4

endmodule

// File: rtl/tcs_edge_detect.sv
module tcs_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              synced;

  assign synced = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= synced;
    end
  end

  always_comb begin
    rise_o = synced & ~prev_q;
    fall_o = ~synced & prev_q;
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R7
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R6

endmodule

// File: rtl/tcs_select_mux.sv
module tcs_select_mux #(
  parameter int unsigned NTAP = tcs_pkg::NUM_TAPS
) (
  input  tcs_pkg::cs_code_e code_i,
  input  logic [NTAP-1:0]   tap_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              en_o
);
  import tcs_pkg::*;

  always_comb begin
    unique case (code_i)
      CS_STOP:     en_o = 1'b0;
      CS_DIRECT:   en_o = 1'b1;
      CS_DIV8:     en_o = tap_i[0];
      CS_DIV64:    en_o = tap_i[1];
      CS_DIV256:   en_o = tap_i[2];
      CS_DIV1024:  en_o = tap_i[3];
      CS_EXT_FALL: en_o = fall_i;
      CS_EXT_RISE: en_o = rise_i;
      default:     en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tcs_clock_select.sv
module tcs_clock_select (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       ext_clk_pin,
  output logic       count_en
);
  import tcs_pkg::*;

  cs_code_e            sel_q;
  cs_code_e            sel_d;
  logic [NUM_TAPS-1:0] taps;
  logic                pin_rise;
  logic                pin_fall;
  logic                en_d;
  logic                en_q;

  always_comb begin
    sel_d = cs_code_e'(clk_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= CS_STOP;
      en_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  tcs_prescaler #(
    .CNT_W (PRESC_W),
    .NTAP  (NUM_TAPS)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (taps)
  );

  tcs_edge_detect #(
    .STAGES (2)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_clk_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  tcs_select_mux #(
    .NTAP (NUM_TAPS)
  ) u_mux (
    .code_i (sel_q),
    .tap_i  (taps),
    .rise_i (pin_rise),
    .fall_i (pin_fall),
    .en_o   (en_d)
  );

  assign count_en = en_q;

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == CS_STOP) |=> !count_en); // R2
  AST_DIRECT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == CS_DIRECT) |=> count_en); // R3
  AST_DIV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && $stable(sel_q) &&
     (sel_q inside {CS_DIV8, CS_DIV64, CS_DIV256, CS_DIV1024})) |=> !count_en); // R4
  AST_EXT_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q == CS_EXT_RISE) && !pin_rise) |=> !count_en); // R8

endmodule

// File: tb/tcs_clock_select_test.sv
module tcs_clock_select_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       ext_clk_pin = 1'b0;
  logic       count_en;

  int checks = 0;
  int errors = 0;
  int unsigned ecount = 0;

  always #4 clk = ~clk;

  tcs_clock_select uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_sel     (clk_sel),
    .ext_clk_pin (ext_clk_pin),
    .count_en    (count_en)
  );

  // rising edges since reset release
  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (edge %0d)", req, what, act, exp, ecount);
    end
  endtask

  task automatic set_sel(input logic [2:0] v);
    @(negedge clk);
    clk_sel = v;
    repeat (2) @(negedge clk);
  endtask

  // R1, R9
  task automatic t_reset;
    clk_sel = 3'b001;
    repeat (3) begin
      @(negedge clk);
      chk(count_en, 1'b0, "R1", "held in reset");
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_en, 1'b0, "R1", "first edge after release");
    @(negedge clk);
    chk(count_en, 1'b1, "R9", "second edge after release");
  endtask

  // R2, R9
  task automatic t_stop;
    clk_sel = 3'b000;
    @(negedge clk);
    chk(count_en, 1'b1, "R9", "one edge after select change");
    @(negedge clk);
    chk(count_en, 1'b0, "R9", "two edges after select change");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(count_en, 1'b0, "R2", "stop code");
    end
  endtask

  // R3
  task automatic t_direct;
    set_sel(3'b001);
    for (int i = 0; i < 30; i++) chk_and_step(1'b1, "R3");
  endtask

  task automatic chk_and_step(input logic exp, input string req);
    chk(count_en, exp, req, "cycle");
    @(negedge clk);
  endtask

  // R4, R5
  task automatic t_divided(input logic [2:0] code, input int unsigned ratio, input int unsigned spans);
    int unsigned pulses;
    int unsigned last;
    int unsigned bad;
    pulses = 0; last = 0; bad = 0;
    set_sel(code);
    for (int i = 0; i < int'(ratio * spans); i++) begin
      logic exp;
      exp = ((ecount % ratio) == 0);
      checks++;
      if (count_en !== exp) begin
        errors++;
        bad++;
        if (bad < 4)
          $display("FAIL R5 divide-by-%0d phase: actual=%b expected=%b (edge %0d)",
                   ratio, count_en, exp, ecount);
      end
      if (count_en === 1'b1) begin
        if (pulses > 0 && (ecount - last) != ratio) begin
          errors++;
          $display("FAIL R4 divide-by-%0d spacing: actual=%0d expected=%0d",
                   ratio, ecount - last, ratio);
        end
        pulses++;
        last = ecount;
      end
      @(negedge clk);
    end
    checks++;
    if (pulses != spans) begin
      errors++;
      $display("FAIL R4 divide-by-%0d pulse count: actual=%0d expected=%0d", ratio, pulses, spans);
    end
  endtask

  // R6, R7, R8: one pin change, then six cycles with a pulse due only at the third
  task automatic pin_step(input logic lvl, input logic pulse_exp, input string req);
    @(negedge clk);
    ext_clk_pin = lvl;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(count_en, (k == 3) ? pulse_exp : 1'b0, req, "external edge window");
    end
  endtask

  task automatic t_ext_fall;
    set_sel(3'b110);
    pin_step(1'b1, 1'b0, "R8");
    pin_step(1'b0, 1'b1, "R6");
    pin_step(1'b1, 1'b0, "R8");
    pin_step(1'b0, 1'b1, "R6");
  endtask

  task automatic t_ext_rise;
    set_sel(3'b111);
    pin_step(1'b1, 1'b1, "R7");
    pin_step(1'b0, 1'b0, "R8");
    pin_step(1'b1, 1'b1, "R7");
    pin_step(1'b0, 1'b0, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_stop();
    t_direct();
    t_divided(3'b010, 8, 6);
    t_divided(3'b011, 64, 4);
    t_divided(3'b010, 8, 3);      // R5: back to /8 with phase unchanged
    t_divided(3'b100, 256, 3);
    t_divided(3'b101, 1024, 3);
    t_ext_fall();
    t_ext_rise();
    t_divided(3'b011, 64, 2);     // R5: prescaler still in phase after external modes
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule